// File: doc/BRIEF.md
# PHY Power-Up and Reset Sequencer

This block steps a two-port USB2 PHY from a fully powered-down state to an operational one. It does this in a fixed order, and each step has a timed settle interval. When an init request arrives, the block switches on the PHY reference clock and waits. It then releases the shared power-on reset and waits again. Next it asks an external agent to perform the clock-enable configuration write and waits for that write to finish. After a further settle interval it releases the UTMI reset of the one port chosen at init time. When a last interval has passed, it raises ready.

An exit request takes the PHY down in the reverse order. All UTMI resets are asserted on the first cycle, the power-on reset on the second, and the reference clock is switched off on the third. An exit request arriving part-way through power-up abandons it and goes straight into this same shutdown order. Every settle interval is a parameter in microseconds. It is turned into a cycle count from the clock frequency parameter and timed by one shared down-counter. All outputs come from registers.

Top module: `phy_pwrseq`

## Requirements
- R1: On a synchronous reset, `refclk_en`, `cfg_req` and `ready` are low, `por_rst` is high and every bit of `utmi_rst` is high. An idle block with no init request keeps these values.
- R2: In the idle state, the clock edge that samples `init_req` high while `exit_req` is low raises `refclk_en`. That same edge captures `port_sel`.
- R3: `por_rst` falls exactly CLK_FREQ_MHZ*REFCLK_US cycles after `refclk_en` rises. `por_rst` is never low while `refclk_en` is low.
- R4: `cfg_req` rises exactly CLK_FREQ_MHZ*POR_US cycles after `por_rst` falls. It stays high until an edge samples `cfg_done` high, and it falls on that edge.
- R5: `utmi_rst[k]` falls exactly CLK_FREQ_MHZ*CFG_US cycles after `cfg_req` falls, where k is the captured `port_sel` value (0 selects bit 0, 1 selects bit 1). Every other port stays in reset.
- R6: `ready` rises exactly CLK_FREQ_MHZ*UTMI_US cycles after the selected UTMI reset falls. While `ready` is high, exactly one UTMI reset is released.
- R7: An `init_req` that arrives while a power-up is in progress, while ready, or during shutdown has no effect. The outputs, the wait timing and the selected port are all unchanged.
- R8: While ready, the edge that samples `exit_req` high drops `ready` and asserts all UTMI resets. The next edge asserts `por_rst`, and the edge after that lowers `refclk_en`.
- R9: An `exit_req` during any power-up phase aborts that phase. For example, if it arrives while `cfg_req` is high, `cfg_req` falls on that edge and the same three-step shutdown order as R8 follows.
- R10: An `exit_req` in the idle state has no effect, and a later init request still starts a normal power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of CLK_FREQ_MHZ MHz |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 1 | Start the power-up sequence |
| exit_req | input | 1 | Shut the PHY down, abort any power-up |
| port_sel | input | PORT_W | Port whose UTMI reset is released, captured at init |
| cfg_done | input | 1 | Configuration write has completed |
| refclk_en | output | 1 | PHY reference clock enable |
| por_rst | output | 1 | Shared power-on reset, active high |
| utmi_rst | output | NUM_PORTS | Per-port UTMI reset, active high |
| cfg_req | output | 1 | Request for the clock-enable configuration write |
| ready | output | 1 | PHY is up and the selected port is out of reset |

## Verification
The checker watches, on every cycle, the ordering relations between the outputs. The power-on reset is never released without the clock, and a UTMI reset is never released while the power-on reset is asserted. At most one port is out of reset, and exactly one while ready. The configuration request is held until done, and the shutdown follows the reverse order. The exact length of each settle interval, the capture of the selected port at init, and the ignoring of late init requests and idle exit requests depend on the sequence of stimulus, so only the bench's directed scenarios show them.

// File: rtl/phy_pwrseq_pkg.sv
package phy_pwrseq_pkg;

   typedef enum logic [3:0] {
      ST_OFF       = 4'd0,
      ST_CLK_WAIT  = 4'd1,
      ST_POR_WAIT  = 4'd2,
      ST_CFG_REQ   = 4'd3,
      ST_CFG_WAIT  = 4'd4,
      ST_UTMI_WAIT = 4'd5,
      ST_READY     = 4'd6,
      ST_SHUT_UTMI = 4'd7,
      ST_SHUT_POR  = 4'd8
   } seq_state_e;

   function automatic int unsigned settle_cycles(input int unsigned mhz,
                                                 input int unsigned usec);
      return mhz * usec;
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/phy_pwrseq_timer.sv
module phy_pwrseq_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/phy_pwrseq_fsm.sv
module phy_pwrseq_fsm
   import phy_pwrseq_pkg::*;
#(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned CLK_CYC  = 4,
   parameter int unsigned POR_CYC  = 4,
   parameter int unsigned CFG_CYC  = 4,
   parameter int unsigned UTMI_CYC = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             init_req,
   input  logic             exit_req,
   input  logic             cfg_done,
   input  logic             expired,
   output logic             timer_load,
   output logic [CNT_W-1:0] timer_val,
   output logic             capture,
   output logic             release_nxt,
   output logic             refclk_q,
   output logic             por_q,
   output logic             cfg_req_q,
   output logic             ready_q
);

   localparam logic [CNT_W-1:0] CLK_LD  = CNT_W'(CLK_CYC - 1);
   localparam logic [CNT_W-1:0] POR_LD  = CNT_W'(POR_CYC - 1);
   localparam logic [CNT_W-1:0] CFG_LD  = CNT_W'(CFG_CYC - 1);
   localparam logic [CNT_W-1:0] UTMI_LD = CNT_W'(UTMI_CYC - 1);

   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF: begin
            if (init_req && !exit_req) state_d = ST_CLK_WAIT;
         end
         ST_CLK_WAIT: begin
            if (exit_req)     state_d = ST_SHUT_UTMI;
            else if (expired) state_d = ST_POR_WAIT;
         end
         ST_POR_WAIT: begin
            if (exit_req)     state_d = ST_SHUT_UTMI;
            else if (expired) state_d = ST_CFG_REQ;
         end
         ST_CFG_REQ: begin
            if (exit_req)      state_d = ST_SHUT_UTMI;
            else if (cfg_done) state_d = ST_CFG_WAIT;
         end
         ST_CFG_WAIT: begin
            if (exit_req)     state_d = ST_SHUT_UTMI;
            else if (expired) state_d = ST_UTMI_WAIT;
         end
         ST_UTMI_WAIT: begin
            if (exit_req)     state_d = ST_SHUT_UTMI;
            else if (expired) state_d = ST_READY;
         end
         ST_READY: begin
            if (exit_req) state_d = ST_SHUT_UTMI;
         end
         ST_SHUT_UTMI: state_d = ST_SHUT_POR;
         ST_SHUT_POR:  state_d = ST_OFF;
         default:      state_d = ST_OFF;
      endcase
   end

   always_comb begin
      timer_load = 1'b0;
      timer_val  = '0;
      if (state_d != state_q) begin
         unique case (state_d)
            ST_CLK_WAIT:  begin timer_load = 1'b1; timer_val = CLK_LD;  end
            ST_POR_WAIT:  begin timer_load = 1'b1; timer_val = POR_LD;  end
            ST_CFG_WAIT:  begin timer_load = 1'b1; timer_val = CFG_LD;  end
            ST_UTMI_WAIT: begin timer_load = 1'b1; timer_val = UTMI_LD; end
            default:      begin timer_load = 1'b0; timer_val = '0;      end
         endcase
      end
   end

   assign capture     = (state_q == ST_OFF) && (state_d == ST_CLK_WAIT);
   assign release_nxt = (state_d == ST_UTMI_WAIT) || (state_d == ST_READY);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= ST_OFF;
         refclk_q  <= 1'b0;
         por_q     <= 1'b1;
         cfg_req_q <= 1'b0;
         ready_q   <= 1'b0;
      end else begin
         state_q   <= state_d;
         refclk_q  <= (state_d != ST_OFF);
         por_q     <= (state_d == ST_OFF) || (state_d == ST_CLK_WAIT) ||
                      (state_d == ST_SHUT_POR);
         cfg_req_q <= (state_d == ST_CFG_REQ);
         ready_q   <= (state_d == ST_READY);
      end
   end

endmodule

// File: rtl/phy_pwrseq_rstbank.sv
module phy_pwrseq_rstbank #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned PORT_W    = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 capture,
   input  logic [PORT_W-1:0]    port_sel,
   input  logic                 release_nxt,
   output logic [NUM_PORTS-1:0] utmi_rst
);

   logic [PORT_W-1:0] sel_q;
   logic [PORT_W-1:0] sel_d;

   assign sel_d = capture ? port_sel : sel_q;

   always_ff @(posedge clk) begin
      if (rst) sel_q <= '0;
      else     sel_q <= sel_d;
   end

   generate
      if (NUM_PORTS == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) utmi_rst[0] <= 1'b1;
            else     utmi_rst[0] <= !release_nxt;
         end
      end else begin : g_multi
         for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
            localparam logic [PORT_W-1:0] IDX = PORT_W'(i);
            always_ff @(posedge clk) begin
               if (rst) utmi_rst[i] <= 1'b1;
               else     utmi_rst[i] <= !(release_nxt && (sel_d == IDX));
            end
         end
      end
   endgenerate

endmodule

// File: rtl/phy_pwrseq.sv
module phy_pwrseq
   import phy_pwrseq_pkg::*;
#(
   parameter int unsigned NUM_PORTS    = 2,
   parameter int unsigned CLK_FREQ_MHZ = 24,
   parameter int unsigned REFCLK_US    = 100,
   parameter int unsigned POR_US       = 300,
   parameter int unsigned CFG_US       = 2000,
   parameter int unsigned UTMI_US      = 2000,
   localparam int unsigned PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 init_req,
   input  logic                 exit_req,
   input  logic [PORT_W-1:0]    port_sel,
   input  logic                 cfg_done,
   output logic                 refclk_en,
   output logic                 por_rst,
   output logic [NUM_PORTS-1:0] utmi_rst,
   output logic                 cfg_req,
   output logic                 ready
);

   localparam int unsigned CLK_CYC  = settle_cycles(CLK_FREQ_MHZ, REFCLK_US);
   localparam int unsigned POR_CYC  = settle_cycles(CLK_FREQ_MHZ, POR_US);
   localparam int unsigned CFG_CYC  = settle_cycles(CLK_FREQ_MHZ, CFG_US);
   localparam int unsigned UTMI_CYC = settle_cycles(CLK_FREQ_MHZ, UTMI_US);
   localparam int unsigned MAX_CYC  = max4(CLK_CYC, POR_CYC, CFG_CYC, UTMI_CYC);
   localparam int unsigned CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("phy_pwrseq: NUM_PORTS must be at least 1");
      end
      if (CLK_CYC < 1 || POR_CYC < 1 || CFG_CYC < 1 || UTMI_CYC < 1) begin : g_bad_wait
         $error("phy_pwrseq: every settle interval must be at least one cycle");
      end
   endgenerate

   logic             expired;
   logic             timer_load;
   logic [CNT_W-1:0] timer_val;
   logic             capture;
   logic             release_nxt;

   phy_pwrseq_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (timer_load),
      .load_val (timer_val),
      .expired  (expired)
   );

   phy_pwrseq_fsm #(
      .CNT_W    (CNT_W),
      .CLK_CYC  (CLK_CYC),
      .POR_CYC  (POR_CYC),
      .CFG_CYC  (CFG_CYC),
      .UTMI_CYC (UTMI_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .init_req    (init_req),
      .exit_req    (exit_req),
      .cfg_done    (cfg_done),
      .expired     (expired),
      .timer_load  (timer_load),
      .timer_val   (timer_val),
      .capture     (capture),
      .release_nxt (release_nxt),
      .refclk_q    (refclk_en),
      .por_q       (por_rst),
      .cfg_req_q   (cfg_req),
      .ready_q     (ready)
   );

   phy_pwrseq_rstbank #(
      .NUM_PORTS (NUM_PORTS),
      .PORT_W    (PORT_W)
   ) u_rstbank (
      .clk         (clk),
      .rst         (rst),
      .capture     (capture),
      .port_sel    (port_sel),
      .release_nxt (release_nxt),
      .utmi_rst    (utmi_rst)
   );

endmodule

// File: rtl/phy_pwrseq_chk.sv
module phy_pwrseq_chk #(
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned PORT_W    = 1
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 init_req,
   input logic                 exit_req,
   input logic [PORT_W-1:0]    port_sel,
   input logic                 cfg_done,
   input logic                 refclk_en,
   input logic                 por_rst,
   input logic [NUM_PORTS-1:0] utmi_rst,
   input logic                 cfg_req,
   input logic                 ready
);

   logic unused_sel;
   assign unused_sel = ^port_sel;

   p_reset_state_r1: assert property (@(posedge clk)
      rst |=> (!refclk_en && por_rst && (&utmi_rst) && !cfg_req && !ready));

   p_idle_stays_r1: assert property (@(posedge clk) disable iff (rst)
      (!refclk_en && !init_req) |=> (!refclk_en && por_rst && (&utmi_rst)));

   p_por_needs_clk_r3: assert property (@(posedge clk) disable iff (rst)
      !por_rst |-> refclk_en);

   p_cfg_context_r4: assert property (@(posedge clk) disable iff (rst)
      cfg_req |-> (refclk_en && !por_rst && (&utmi_rst)));

   p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (cfg_req && !cfg_done && !exit_req) |=> cfg_req);

   p_utmi_after_por_r5: assert property (@(posedge clk) disable iff (rst)
      !(&utmi_rst) |-> !por_rst);

   p_one_port_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(~utmi_rst));

   p_ready_port_r6: assert property (@(posedge clk) disable iff (rst)
      ready |-> ($countones(~utmi_rst) == 1));

   p_exit_drop_r8: assert property (@(posedge clk) disable iff (rst)
      (exit_req && ready) |=> (!ready && (&utmi_rst) && !por_rst));

   p_por_rise_order_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(por_rst)) |-> (&utmi_rst));

   p_clk_fall_order_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(refclk_en)) |-> $past(por_rst));

   p_abort_cfg_r9: assert property (@(posedge clk) disable iff (rst)
      (exit_req && cfg_req) |=> (!cfg_req && (&utmi_rst)));

endmodule

bind phy_pwrseq phy_pwrseq_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PORT_W    (PORT_W)
) u_chk (.*);

// File: tb/sim_phy_pwrseq.sv
module sim_phy_pwrseq;

   localparam int CLK_PERIOD = 10;
   localparam int MHZ  = 1;
   localparam int T_CLK  = 5;
   localparam int T_POR  = 7;
   localparam int T_CFG  = 9;
   localparam int T_UTMI = 11;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       init_req = 1'b0;
   logic       exit_req = 1'b0;
   logic       port_sel = 1'b0;
   logic       cfg_done = 1'b0;
   logic       refclk_en, por_rst, cfg_req, ready;
   logic [1:0] utmi_rst;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_pwrseq #(
      .NUM_PORTS    (2),
      .CLK_FREQ_MHZ (MHZ),
      .REFCLK_US    (T_CLK),
      .POR_US       (T_POR),
      .CFG_US       (T_CFG),
      .UTMI_US      (T_UTMI)
   ) u0 (
      .clk (clk), .rst (rst), .init_req (init_req), .exit_req (exit_req),
      .port_sel (port_sel), .cfg_done (cfg_done), .refclk_en (refclk_en),
      .por_rst (por_rst), .utmi_rst (utmi_rst), .cfg_req (cfg_req), .ready (ready)
   );

   // observed vector: {refclk_en, por_rst, utmi_rst[1], utmi_rst[0], cfg_req, ready}
   localparam logic [5:0] V_OFF = 6'b011100;

   function automatic logic [5:0] outs();
      return {refclk_en, por_rst, utmi_rst[1], utmi_rst[0], cfg_req, ready};
   endfunction

   task automatic chk(input string req, input logic [5:0] exp);
      checks++;
      if (outs() !== exp) begin
         failures++;
         $display("FAIL %s: outputs actual=%b expected=%b at %0t", req, outs(), exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [5:0] rel(input logic p, input logic rdy);
      return {1'b1, 1'b0, (p ? 2'b01 : 2'b10), 1'b0, rdy};
   endfunction

   // full power-up to ready; poke injects late init requests (R7)
   task automatic do_init(input logic p, input bit poke, input int cfg_lag);
      port_sel = p; init_req = 1'b1;
      step(1);
      init_req = 1'b0;
      chk("R2 clock on", 6'b111100);
      if (poke) begin
         step(2);
         init_req = 1'b1; port_sel = ~p;
         step(1);
         init_req = 1'b0;
         step(1);
      end else begin
         step(T_CLK - 1);
      end
      chk("R3 por held", 6'b111100);
      step(1);
      chk("R3 por released", 6'b101100);
      step(T_POR - 1);
      chk("R4 cfg not yet", 6'b101100);
      step(1);
      chk("R4 cfg_req up", 6'b101110);
      step(cfg_lag);
      chk("R4 cfg_req held", 6'b101110);
      cfg_done = 1'b1;
      step(1);
      cfg_done = 1'b0;
      chk("R4 cfg_req drops", 6'b101100);
      step(T_CFG - 1);
      chk("R5 utmi held", 6'b101100);
      step(1);
      chk("R5 port released", rel(p, 1'b0));
      if (poke) begin
         init_req = 1'b1; port_sel = ~p;
         step(1);
         init_req = 1'b0;
         step(T_UTMI - 2);
      end else begin
         step(T_UTMI - 1);
      end
      chk("R6 not ready", rel(p, 1'b0));
      step(1);
      chk("R6 ready", rel(p, 1'b1));
   endtask

   task automatic do_exit(input string req, input bit poke_init);
      exit_req = 1'b1;
      step(1);
      exit_req = 1'b0;
      chk({req, " utmi first"}, 6'b101100);
      if (poke_init) init_req = 1'b1;
      step(1);
      init_req = 1'b0;
      chk({req, " por second"}, 6'b111100);
      step(1);
      chk({req, " clock off"}, V_OFF);
      step(2);
      chk({req, " stays off"}, V_OFF);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(3);
      chk("R1 reset", V_OFF);
      rst = 1'b0;
      step(4);
      chk("R1 idle", V_OFF);
   endtask

   task automatic t_port0_plain();
      do_init(1'b0, 1'b0, 0);
      init_req = 1'b1; port_sel = 1'b1;
      step(1);
      init_req = 1'b0;
      step(2);
      chk("R7 init while ready", rel(1'b0, 1'b1));
      do_exit("R8", 1'b0);
   endtask

   task automatic t_port1_pokes();
      do_init(1'b1, 1'b1, 3);
      do_exit("R7 shutdown init", 1'b1);
   endtask

   task automatic t_abort_cfg();
      port_sel = 1'b0; init_req = 1'b1;
      step(1);
      init_req = 1'b0;
      step(T_CLK + T_POR + 2);
      chk("R9 waiting for cfg", 6'b101110);
      do_exit("R9 abort", 1'b0);
   endtask

   task automatic t_exit_idle();
      exit_req = 1'b1;
      step(2);
      exit_req = 1'b0;
      step(1);
      chk("R10 exit idle", V_OFF);
      do_init(1'b1, 1'b0, 1);
      do_exit("R10 after idle exit", 1'b0);
   endtask

   initial begin
      step(1);
      t_reset();
      t_port0_plain();
      t_port1_pokes();
      t_abort_cfg();
      t_exit_idle();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule